// File: doc/BRIEF.md
# Audio Word-Clock Timing Guard

This block runs in the master-clock domain and checks whether incoming audio timing can be trusted. Its word-clock and bit-clock inputs are already synchronised to the master clock. Every rising edge of the word clock marks a frame boundary. At each boundary the block measures two things: the frame length in master-clock cycles, and the number of bit-clock rising edges seen during the frame.

The frame length is checked against a reference. The block captures this reference once consecutive frames agree, and every later frame is compared with that fixed value. The bit-clock count is checked against a small set of legal ratios, and an illegal ratio becomes a fault only when it persists. Either fault, or a word clock that stops altogether, produces a one-cycle reinitialise pulse and forces both sample outputs to zero. The block lifts the mute only after the timing has relocked and a run of clean frames has been seen, and it does so on a frame boundary.

The surrounding logic passes its left and right samples through this block. It uses the reinitialise pulse to restart its own pipeline.

Top module: `audio_timing_guard`

## Requirements
- R1: While reset is asserted and right after it, `mute` is 1, `reinit` is 0 and both sample outputs are all-zero.
- R2: A frame's period is the number of master-clock cycles between two consecutive sampled rising edges of `wclk_s`. The first edge after reset or after a timeout is not measured. From reset, with a steady period and a legal bit count, the reference locks at the 5th edge (4 agreeing measured frames). `mute` falls in the cycle after the 8th edge.
- R3: Once locked, a measured period that differs from the locked reference by at most 5 cycles causes no fault. A difference of 6 or more declares a fault in the cycle after that edge. The reference does not follow gradual drift.
- R4: A frame's bit-clock ratio is legal when it contains exactly 32, 48, 64, 128 or 256 rising edges of `bclk_s`. Any other count is illegal.
- R5: One to four consecutive illegal frames declare no fault. The fifth consecutive illegal frame declares a fault. A legal frame clears the run.
- R6: When 4096 master-clock cycles pass with no `wclk_s` rising edge, a fault is declared and the lock is dropped. Measurement restarts from the next edge.
- R7: Each declared fault produces exactly one single-cycle `reinit` pulse, and `mute` is 1 in that cycle.
- R8: While `mute` is 1 both outputs are all-zero (two's complement zero). While `mute` is 0 each output equals its input from one cycle earlier.
- R9: After a fault, `mute` stays 1 until the reference has relocked and 4 consecutive frames are both within tolerance and of a legal ratio. It falls only in the cycle after a word-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_s | input | 1 | Word clock, synchronised to clk |
| bclk_s | input | 1 | Bit clock, synchronised to clk |
| in_left | input | SW | Left input sample |
| in_right | input | SW | Right input sample |
| out_left | output | SW | Left output sample, zero while muted |
| out_right | output | SW | Right output sample, zero while muted |
| mute | output | 1 | Outputs forced to zero |
| reinit | output | 1 | One-cycle pulse when a fault is declared |

## Verification
The bench drives frames of constant length and shows that the lock-then-release sequence takes exactly eight edges. It then sweeps single-frame period offsets from -7 to +7 around a locked 512-cycle frame, which separates an inclusive ±5 window from a window that is off by one in either direction. A two-step drift of 4 cycles then 8 cycles distinguishes a fixed reference from one that tracks the previous frame. Runs of one to six illegal bit counts, drawn from values next to each legal ratio, separate a limit of four from three or five. A legal frame placed between two runs of four shows that the run counter is cleared. A stopped word clock checks the timeout and the recovery that follows.

// File: rtl/atg_pkg.sv
package atg_pkg;

    localparam int BCNT_W = 10;

    // Legal bit-clock edges per word-clock period
    function automatic logic bclk_ratio_ok(input logic [BCNT_W-1:0] n);
        case (n)
            10'd32, 10'd48, 10'd64, 10'd128, 10'd256: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/atg_rise_det.sv
module atg_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/atg_frame_meter.sv
module atg_frame_meter
    import atg_pkg::*;
#(
    parameter int TIMEOUT = 4096,
    localparam int PW = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrise_i,
    input  logic              brise_i,
    output logic              meas_o,
    output logic [PW-1:0]     period_o,
    output logic [BCNT_W-1:0] bits_o,
    output logic              timeout_o
);
    localparam logic [BCNT_W-1:0] BMAX = '1;

    typedef struct packed {
        logic              seen;
        logic [PW-1:0]     pcnt;
        logic [BCNT_W-1:0] bcnt;
    } meter_t;

    meter_t st_d, st_q;
    logic   bstep;

    always_comb begin
        st_d      = st_q;
        timeout_o = 1'b0;
        bstep     = brise_i && (st_q.bcnt != BMAX);
        period_o  = st_q.pcnt + PW'(1);
        bits_o    = bstep ? st_q.bcnt + BCNT_W'(1) : st_q.bcnt;
        meas_o    = wrise_i & st_q.seen;
        if (wrise_i) begin
            st_d.seen = 1'b1;
            st_d.pcnt = '0;
            st_d.bcnt = '0;
        end else begin
            if (st_q.pcnt == PW'(TIMEOUT - 1)) begin
                timeout_o = 1'b1;
                st_d.seen = 1'b0;
                st_d.pcnt = PW'(TIMEOUT);
            end else if (st_q.pcnt != PW'(TIMEOUT)) begin
                st_d.pcnt = st_q.pcnt + PW'(1);
            end
            if (bstep) st_d.bcnt = st_q.bcnt + BCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/audio_timing_guard.sv
module audio_timing_guard
    import atg_pkg::*;
#(
    parameter int SW            = 24,
    parameter int TOL           = 5,
    parameter int LOCK_FRAMES   = 4,
    parameter int BAD_LIMIT     = 4,
    parameter int RESYNC_FRAMES = 4,
    parameter int TIMEOUT       = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wclk_s,
    input  logic          bclk_s,
    input  logic [SW-1:0] in_left,
    input  logic [SW-1:0] in_right,
    output logic [SW-1:0] out_left,
    output logic [SW-1:0] out_right,
    output logic          mute,
    output logic          reinit
);
    localparam int PW  = $clog2(TIMEOUT + 1);
    localparam int AW  = $clog2(LOCK_FRAMES + 1);
    localparam int BRW = $clog2(BAD_LIMIT + 2);
    localparam int GW  = $clog2(RESYNC_FRAMES + 1);

    typedef struct packed {
        logic           locked;
        logic [PW-1:0]  ref_p;
        logic [PW-1:0]  cand;
        logic [AW-1:0]  agree;
        logic [BRW-1:0] badrun;
        logic [GW-1:0]  good;
        logic           mute;
        logic           reinit;
        logic [SW-1:0]  out_l;
        logic [SW-1:0]  out_r;
    } guard_t;

    guard_t st_d, st_q;

    logic              wrise, brise, meas, tmo;
    logic [PW-1:0]     period;
    logic [BCNT_W-1:0] bits;
    logic              fault, bits_ok, good_frame;

    atg_rise_det u_wdet (.clk(clk), .rst_n(rst_n), .sig_i(wclk_s), .rise_o(wrise));
    atg_rise_det u_bdet (.clk(clk), .rst_n(rst_n), .sig_i(bclk_s), .rise_o(brise));

    atg_frame_meter #(.TIMEOUT(TIMEOUT)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrise_i  (wrise),
        .brise_i  (brise),
        .meas_o   (meas),
        .period_o (period),
        .bits_o   (bits),
        .timeout_o(tmo)
    );

    function automatic logic near(input logic [PW-1:0] a, input logic [PW-1:0] b);
        logic [PW-1:0] diff;
        diff = (a >= b) ? a - b : b - a;
        return diff <= PW'(TOL);
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.reinit = 1'b0;
        fault       = 1'b0;
        good_frame  = 1'b0;
        bits_ok     = bclk_ratio_ok(bits);

        if (tmo) begin
            st_d.locked = 1'b0;
            st_d.agree  = '0;
            fault       = 1'b1;
        end

        if (meas) begin
            // master-clock period check
            if (st_q.locked) begin
                if (!near(period, st_q.ref_p)) begin
                    st_d.locked = 1'b0;
                    st_d.agree  = AW'(1);
                    st_d.cand   = period;
                    fault       = 1'b1;
                end
            end else begin
                if (st_q.agree == '0 || near(period, st_q.cand))
                    st_d.agree = st_q.agree + AW'(1);
                else
                    st_d.agree = AW'(1);
                st_d.cand = period;
                if (st_d.agree == AW'(LOCK_FRAMES)) begin
                    st_d.locked = 1'b1;
                    st_d.ref_p  = period;
                    st_d.agree  = '0;
                end
            end
            // bit-clock persistence check
            if (bits_ok) begin
                st_d.badrun = '0;
            end else begin
                if (st_q.badrun == BRW'(BAD_LIMIT)) fault = 1'b1;
                if (st_q.badrun <= BRW'(BAD_LIMIT))
                    st_d.badrun = st_q.badrun + BRW'(1);
            end
            // resynchronisation
            good_frame = st_d.locked & bits_ok;
            if (!good_frame)
                st_d.good = '0;
            else if (st_q.good != GW'(RESYNC_FRAMES))
                st_d.good = st_q.good + GW'(1);
            if (st_q.mute && good_frame && st_d.good == GW'(RESYNC_FRAMES))
                st_d.mute = 1'b0;
        end

        if (fault) begin
            st_d.mute   = 1'b1;
            st_d.reinit = 1'b1;
            st_d.good   = '0;
        end

        st_d.out_l = st_d.mute ? '0 : in_left;
        st_d.out_r = st_d.mute ? '0 : in_right;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mute <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_left  = st_q.out_l;
    assign out_right = st_q.out_r;
    assign mute      = st_q.mute;
    assign reinit    = st_q.reinit;
endmodule

// File: rtl/atg_checker.sv
module atg_checker #(
    parameter int SW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wclk_s,
    input logic [SW-1:0] in_left,
    input logic [SW-1:0] in_right,
    input logic [SW-1:0] out_left,
    input logic [SW-1:0] out_right,
    input logic          mute,
    input logic          reinit
);
    // R8
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> (out_left == '0 && out_right == '0));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute |-> (out_left == $past(in_left) && out_right == $past(in_right)));

    // R7
    reinit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !reinit);

    // R7
    reinit_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |-> mute);

    // R9
    release_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> $past(wclk_s));
endmodule

bind audio_timing_guard atg_checker #(.SW(SW)) u_atg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wclk_s   (wclk_s),
    .in_left  (in_left),
    .in_right (in_right),
    .out_left (out_left),
    .out_right(out_right),
    .mute     (mute),
    .reinit   (reinit)
);

// File: tb/tb_audio_timing_guard.sv
module tb_audio_timing_guard;
    localparam int SW = 24;
    localparam int P0 = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wclk_s = 1'b0;
    logic          bclk_s = 1'b0;
    logic [SW-1:0] in_left = '0;
    logic [SW-1:0] in_right = '0;
    logic [SW-1:0] out_left, out_right;
    logic          mute, reinit;

    audio_timing_guard dut (
        .clk(clk), .rst_n(rst_n), .wclk_s(wclk_s), .bclk_s(bclk_s),
        .in_left(in_left), .in_right(in_right),
        .out_left(out_left), .out_right(out_right),
        .mute(mute), .reinit(reinit)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, n_reinit = 0, exp_reinit = 0;
    // frame-level expectation model
    bit m_seen = 0, m_locked = 0, m_mute = 1;
    int m_ref = 0, m_cand = 0, m_agree = 0, m_bad = 0, m_good = 0;
    int pp = 0, pb = 0;

    always @(negedge clk) if (rst_n && reinit) n_reinit++;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit ratio_ok(int b);
        return b == 32 || b == 48 || b == 64 || b == 128 || b == 256;
    endfunction

    function automatic int absd(int a, int b);
        return a > b ? a - b : b - a;
    endfunction

    task automatic model_step(int p, int b, output bit flt);
        bit ok, gf;
        flt = 0;
        ok  = ratio_ok(b);
        if (m_locked) begin
            if (absd(p, m_ref) > 5) begin
                m_locked = 0; m_agree = 1; m_cand = p; flt = 1;
            end
        end else begin
            if (m_agree == 0 || absd(p, m_cand) <= 5) m_agree++;
            else m_agree = 1;
            m_cand = p;
            if (m_agree >= 4) begin m_locked = 1; m_ref = p; m_agree = 0; end
        end
        if (ok) m_bad = 0;
        else begin
            if (m_bad == 4) flt = 1;
            if (m_bad < 5) m_bad++;
        end
        gf = m_locked && ok;
        m_good = gf ? ((m_good < 4) ? m_good + 1 : 4) : 0;
        if (m_mute && gf && m_good >= 4) m_mute = 0;
        if (flt) begin m_mute = 1; m_good = 0; exp_reinit++; end
    endtask

    // One word-clock frame of P cycles with B bit-clock rising edges
    task automatic run_frame(int P, int B, string req);
        int s, h;
        bit flt;
        s = (B > 0) ? P / B : P + 1;
        h = (s / 2 > 0) ? s / 2 : 1;
        for (int off = 0; off < P; off++) begin
            @(negedge clk);
            if (off == 1) begin
                flt = 0;
                if (m_seen) model_step(pp, pb, flt);
                check(req, "mute", mute, m_mute);
                check("R7", "reinit", reinit, flt);
                check("R8", "out_left", out_left, m_mute ? 0 : in_left);
                check("R8", "out_right", out_right, m_mute ? 0 : in_right);
            end
            wclk_s   = (off < P / 2);
            bclk_s   = (B > 0) && (off < B * s) && ((off % s) >= h);
            in_left  = SW'($urandom);
            in_right = SW'($urandom);
        end
        m_seen = 1; pp = P; pb = B;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wclk_s = 0; bclk_s = 0;
        end
        m_seen = 0; m_locked = 0; m_agree = 0; m_good = 0; m_mute = 1;
        exp_reinit++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int inv[12] = '{31, 33, 47, 49, 63, 65, 127, 129, 255, 200, 100, 16};
        int k;
        int vb[5] = '{32, 48, 64, 128, 256};
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "mute", mute, 1);
        check("R1", "reinit", reinit, 0);
        check("R1", "out_left", out_left, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "mute after release", mute, 1);

        // R2: clean lock and first release on the 8th edge
        for (int f = 0; f < 8; f++) run_frame(P0, 64, "R2");
        check("R2", "model released", m_mute, 0);
        run_frame(P0, 64, "R2");
        check("R2", "mute after 8 edges", mute, 0);

        // R4: each legal ratio keeps the output live
        for (int i = 0; i < 5; i++) begin
            run_frame(P0, vb[i], "R4");
            run_frame(P0, vb[i], "R4");
        end

        // R3: offset sweep around the locked period, then recovery (R9)
        for (int d = -7; d <= 7; d++) begin
            run_frame(P0 + d, 64, "R3");
            for (int f = 0; f < 9; f++) run_frame(P0, 64, "R9");
        end
        // R3: reference is fixed, gradual drift still faults
        run_frame(P0 + 4, 64, "R3");
        run_frame(P0 + 8, 64, "R3");
        for (int f = 0; f < 9; f++) run_frame(P0, 64, "R9");
        check("R9", "released after drift", mute, 0);

        // R5: runs of 1..6 illegal frames
        k = 0;
        for (int n = 1; n <= 6; n++) begin
            for (int f = 0; f < n; f++) begin
                run_frame(P0, inv[k % 12], "R5");
                k++;
            end
            for (int f = 0; f < 6; f++) run_frame(P0, 64, "R5");
        end
        // R5: a legal frame clears the run
        for (int f = 0; f < 4; f++) run_frame(P0, inv[f], "R5");
        run_frame(P0, 48, "R5");
        for (int f = 0; f < 4; f++) run_frame(P0, inv[f + 4], "R5");
        run_frame(P0, 48, "R5");
        check("R5", "no mute after split runs", mute, 0);

        // R6: stopped word clock
        idle(4200);
        @(negedge clk);
        check("R6", "mute after timeout", mute, 1);
        check("R6", "reinit count", n_reinit, exp_reinit);
        for (int f = 0; f < 10; f++) run_frame(P0, 64, "R6");
        check("R6", "released after restart", mute, 0);

        @(negedge clk);
        check("R7", "total reinit pulses", n_reinit, exp_reinit);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule